// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash device. Each write strobe carries a data word and an address. The block decodes only the low byte of the data word as an 8-bit command. It keeps track of which source the read path returns: the array, the identifier bytes, or the status register. It runs the two-cycle program and erase sequences and sends one-cycle start requests to a separate program/erase engine. It also holds the suspended state of an erase.

The engine reports that an operation has finished with a one-cycle `eng_done` strobe. Alongside that strobe it can flag a failed operation or a supply fault. The status register combines bits the block computes itself (ready and erase-suspended) with sticky error bits. Software can clear the sticky error bits only with the clear command. After any operation starts, the read path switches to the status register and stays there until software selects array reads again.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is array (`rd_sel` = 00), `status` = 80h, and no request output is high.
- R2: Only bits 7:0 of `wr_data` are decoded as the command. The upper bits never change which command is recognised.
- R3: In idle state, FFh selects array reads (`rd_sel` 00) and 70h selects status reads (`rd_sel` 10). In status read, `rd_data` equals `status`.
- R4: 90h selects identifier reads (`rd_sel` 01). `rd_data` returns MFR_ID while `rd_a0` is 0 and DEV_ID while `rd_a0` is 1.
- R5: After 40h or 10h, the next write raises `prog_start` for one cycle in the cycle after that write. In the same cycle `prog_addr` and `prog_data` hold that write's address and full data word. The read source becomes status, and status bit 7 (ready) is 0 until `eng_done`.
- R6: After 20h, a D0h write raises `erase_start` for one cycle, and `erase_addr` holds the address of the D0h cycle. Status bit 7 is 0 until `eng_done`.
- R7: After 20h, any code other than D0h starts no erase. It sets status bits 5 and 4, selects status reads, and returns to idle.
- R8: B0h during a running erase raises `susp_req` for one cycle and gives status C0h (bit 6 set, ready). While suspended, only FFh, 70h and D0h act. D0h raises `resume_req`, clears bit 6 and selects status reads.
- R9: Code 00h and codes with no assigned meaning, including D0h and B0h in idle, change neither the read source nor any request output.
- R10: 50h clears status bits 5:3. Otherwise those bits stay set across any other command.
- R11: When `eng_done` arrives with `eng_fail` high, status bit 4 is set after a program and bit 5 after an erase. `eng_done` with `eng_vfault` high sets bit 3.
- R12: While a program or an unsuspended erase runs, writes have no effect, except B0h during an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | DATA_W | Command byte (low 8 bits) or program data |
| wr_addr | input | ADDR_W | Write address |
| rd_a0 | input | 1 | Read address bit 0, selects identifier byte |
| eng_done | input | 1 | Engine finished the current operation (one cycle) |
| eng_fail | input | 1 | Qualifies eng_done: operation failed |
| eng_vfault | input | 1 | Qualifies eng_done: supply fault seen |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | DATA_W | Program data |
| erase_start | output | 1 | One-cycle erase request |
| erase_addr | output | ADDR_W | Block address of the erase |
| susp_req | output | 1 | One-cycle erase-suspend request |
| resume_req | output | 1 | One-cycle erase-resume request |
| rd_sel | output | 2 | Read source: 00 array, 01 identifier, 10 status |
| rd_data | output | 8 | Identifier or status byte for the read path |
| status | output | 8 | Status register |

## Verification
Every result of a write is due one clock edge after the edge that captures the write. This covers the read source, the status bits and the one-cycle request pulses. An `eng_done` strobe likewise takes effect on status one edge after it is sampled. Each bench task drives stimulus on a falling edge and holds it across exactly one rising edge. It then checks at the next falling edge, which is the only cycle in which a pulse is high. One further falling edge confirms that the pulse has dropped. With the default combinational read mux, `rd_data` follows `rd_a0` in the same cycle, so the bench changes `rd_a0` and checks after a short delay.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   typedef enum logic [1:0] {
      RD_ARRAY  = 2'b00,
      RD_ID     = 2'b01,
      RD_STATUS = 2'b10
   } rd_src_e;

   typedef enum logic [3:0] {
      C_NONE,
      C_READ_ARRAY,
      C_READ_ID,
      C_READ_STAT,
      C_CLR_STAT,
      C_PROG_SETUP,
      C_ERASE_SETUP,
      C_CONFIRM,
      C_SUSPEND
   } cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PSETUP,
      S_ESETUP,
      S_PRUN,
      S_ERUN,
      S_ESUSP
   } seq_e;

   localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
   localparam logic [7:0] OP_READ_ID     = 8'h90;
   localparam logic [7:0] OP_READ_STAT   = 8'h70;
   localparam logic [7:0] OP_CLR_STAT    = 8'h50;
   localparam logic [7:0] OP_PROG_A      = 8'h40;
   localparam logic [7:0] OP_PROG_B      = 8'h10;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
   localparam logic [7:0] OP_CONFIRM     = 8'hD0;
   localparam logic [7:0] OP_SUSPEND     = 8'hB0;

   localparam int unsigned ST_READY = 7;
   localparam int unsigned ST_SUSP  = 6;
   localparam int unsigned ST_EERR  = 5;
   localparam int unsigned ST_PERR  = 4;
   localparam int unsigned ST_VERR  = 3;

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
   import fcc_pkg::*;
(
   input  logic [7:0] code,
   output cmd_e       cmd
);

   always_comb begin
      unique case (code)
         OP_READ_ARRAY:         cmd = C_READ_ARRAY;
         OP_READ_ID:            cmd = C_READ_ID;
         OP_READ_STAT:          cmd = C_READ_STAT;
         OP_CLR_STAT:           cmd = C_CLR_STAT;
         OP_PROG_A, OP_PROG_B:  cmd = C_PROG_SETUP;
         OP_ERASE_SETUP:        cmd = C_ERASE_SETUP;
         OP_CONFIRM:            cmd = C_CONFIRM;
         OP_SUSPEND:            cmd = C_SUSPEND;
         default:               cmd = C_NONE;
      endcase
   end

endmodule

// File: rtl/fcc_status.sv
module fcc_status
   import fcc_pkg::*;
#(
   parameter int unsigned STICKY_LO = 3,
   parameter int unsigned STICKY_HI = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [STICKY_HI-STICKY_LO:0]   set_bits,
   input  logic                           clr,
   input  logic                           ready,
   input  logic                           suspended,
   output logic [7:0]                     stat
);

   localparam int unsigned NSTICKY = STICKY_HI - STICKY_LO + 1;

   initial begin
      assert (STICKY_HI < ST_SUSP && STICKY_LO <= STICKY_HI)
         else $error("fcc_status: sticky field must lie below the suspend bit");
   end

   logic [NSTICKY-1:0] sticky_q;

   for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           sticky_q[i] <= 1'b0;
         else if (set_bits[i]) sticky_q[i] <= 1'b1;
         else if (clr)         sticky_q[i] <= 1'b0;
      end
   end

   always_comb begin
      stat = '0;
      stat[ST_READY] = ready;
      stat[ST_SUSP]  = suspended;
      stat[STICKY_HI:STICKY_LO] = sticky_q;
   end

   // R10: clear empties the sticky field on the next cycle
   assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set_bits == '0) |=> (stat[STICKY_HI:STICKY_LO] == '0));

   // R10: without clear, no sticky bit ever falls
   assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((stat[STICKY_HI:STICKY_LO] & $past(stat[STICKY_HI:STICKY_LO]))
                == $past(stat[STICKY_HI:STICKY_LO])));

endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  cmd_e              cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              eng_done,
   input  logic              eng_fail,
   input  logic              eng_vfault,
   output seq_e              state,
   output rd_src_e           rd_src,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_start,
   output logic [ADDR_W-1:0] erase_addr,
   output logic              susp_req,
   output logic              resume_req,
   output logic              clr_stat,
   output logic              set_eerr,
   output logic              set_perr,
   output logic              set_verr,
   output logic              ready
);

   logic running;
   logic seq_err;

   assign running  = (state == S_PRUN) || (state == S_ERUN);
   assign ready    = !running;
   assign clr_stat = wr_en && (state == S_IDLE) && (cmd == C_CLR_STAT);
   assign seq_err  = wr_en && (state == S_ESETUP) && (cmd != C_CONFIRM);
   assign set_eerr = seq_err || ((state == S_ERUN) && eng_done && eng_fail);
   assign set_perr = seq_err || ((state == S_PRUN) && eng_done && eng_fail);
   assign set_verr = running && eng_done && eng_vfault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         rd_src      <= RD_ARRAY;
         prog_start  <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
         erase_start <= 1'b0;
         erase_addr  <= '0;
         susp_req    <= 1'b0;
         resume_req  <= 1'b0;
      end else begin
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         susp_req    <= 1'b0;
         resume_req  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (wr_en) begin
                  case (cmd)
                     C_READ_ARRAY:  rd_src <= RD_ARRAY;
                     C_READ_ID:     rd_src <= RD_ID;
                     C_READ_STAT:   rd_src <= RD_STATUS;
                     C_PROG_SETUP:  state  <= S_PSETUP;
                     C_ERASE_SETUP: state  <= S_ESETUP;
                     default:       ;
                  endcase
               end
            end
            S_PSETUP: begin
               if (wr_en) begin
                  prog_start <= 1'b1;
                  prog_addr  <= wr_addr;
                  prog_data  <= wr_data;
                  rd_src     <= RD_STATUS;
                  state      <= S_PRUN;
               end
            end
            S_ESETUP: begin
               if (wr_en) begin
                  rd_src <= RD_STATUS;
                  if (cmd == C_CONFIRM) begin
                     erase_start <= 1'b1;
                     erase_addr  <= wr_addr;
                     state       <= S_ERUN;
                  end else begin
                     state <= S_IDLE;
                  end
               end
            end
            S_PRUN: begin
               if (eng_done) state <= S_IDLE;
            end
            S_ERUN: begin
               if (eng_done) begin
                  state <= S_IDLE;
               end else if (wr_en && cmd == C_SUSPEND) begin
                  susp_req <= 1'b1;
                  rd_src   <= RD_STATUS;
                  state    <= S_ESUSP;
               end
            end
            S_ESUSP: begin
               if (wr_en) begin
                  case (cmd)
                     C_READ_ARRAY: rd_src <= RD_ARRAY;
                     C_READ_STAT:  rd_src <= RD_STATUS;
                     C_CONFIRM: begin
                        resume_req <= 1'b1;
                        rd_src     <= RD_STATUS;
                        state      <= S_ERUN;
                     end
                     default: ;
                  endcase
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R6: an erase request follows only a confirm write
   assert_erase_after_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> $past(wr_en && cmd == C_CONFIRM));

   // R5: any started operation reads status and reports busy
   assert_start_reads_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start || erase_start) |-> (rd_src == RD_STATUS && !ready));

   // R9: engine-side requests never overlap
   assert_requests_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, erase_start, susp_req, resume_req}));

   // R8: the suspended state is left only by a write
   assert_suspend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ESUSP && !wr_en) |=> (state == S_ESUSP));

   // R12: a running program ignores writes until done
   assert_prog_run_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PRUN && !eng_done) |=> (state == S_PRUN && $stable(rd_src)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 18,
   parameter logic [7:0]  MFR_ID    = 8'hA5,
   parameter logic [7:0]  DEV_ID    = 8'h5A,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_a0,
   input  logic              eng_done,
   input  logic              eng_fail,
   input  logic              eng_vfault,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_start,
   output logic [ADDR_W-1:0] erase_addr,
   output logic              susp_req,
   output logic              resume_req,
   output logic [1:0]        rd_sel,
   output logic [7:0]        rd_data,
   output logic [7:0]        status
);

   localparam int unsigned NSTICKY = ST_EERR - ST_VERR + 1;

   initial begin
      assert (DATA_W >= 8) else $error("flash_cmd_ctrl: DATA_W must hold a command byte");
      assert (ADDR_W >= 1) else $error("flash_cmd_ctrl: ADDR_W must be positive");
   end

   cmd_e    cmd;
   seq_e    state;
   rd_src_e rd_src;
   logic    clr_stat, set_eerr, set_perr, set_verr, ready;
   logic [NSTICKY-1:0] set_bits;
   logic [7:0] rd_mux;

   fcc_decode u_decode (
      .code (wr_data[7:0]),
      .cmd  (cmd)
   );

   fcc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .cmd         (cmd),
      .wr_data     (wr_data),
      .wr_addr     (wr_addr),
      .eng_done    (eng_done),
      .eng_fail    (eng_fail),
      .eng_vfault  (eng_vfault),
      .state       (state),
      .rd_src      (rd_src),
      .prog_start  (prog_start),
      .prog_addr   (prog_addr),
      .prog_data   (prog_data),
      .erase_start (erase_start),
      .erase_addr  (erase_addr),
      .susp_req    (susp_req),
      .resume_req  (resume_req),
      .clr_stat    (clr_stat),
      .set_eerr    (set_eerr),
      .set_perr    (set_perr),
      .set_verr    (set_verr),
      .ready       (ready)
   );

   assign set_bits = {set_eerr, set_perr, set_verr};

   fcc_status #(.STICKY_LO(ST_VERR), .STICKY_HI(ST_EERR)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bits  (set_bits),
      .clr       (clr_stat),
      .ready     (ready),
      .suspended (state == S_ESUSP),
      .stat      (status)
   );

   assign rd_sel = rd_src;

   always_comb begin
      case (rd_src)
         RD_ID:     rd_mux = rd_a0 ? DEV_ID : MFR_ID;
         RD_STATUS: rd_mux = status;
         default:   rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rdata_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rdata_comb
      assign rd_data = rd_mux;
   end

   // R8: suspended implies ready at the status port
   assert_suspend_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_SUSP] |-> status[ST_READY]);

   // R7: a sequence error leaves both error bits set on the next cycle
   assert_seq_err_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_eerr && set_perr) |=> (status[ST_EERR] && status[ST_PERR] && rd_sel == RD_STATUS));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

   localparam int DW = 16;
   localparam int AW = 18;
   localparam logic [7:0] MFR = 8'hA5;
   localparam logic [7:0] DEV = 8'h5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] wr_addr = '0;
   logic          rd_a0 = 1'b0;
   logic          eng_done = 1'b0, eng_fail = 1'b0, eng_vfault = 1'b0;
   logic          prog_start, erase_start, susp_req, resume_req;
   logic [AW-1:0] prog_addr, erase_addr;
   logic [DW-1:0] prog_data;
   logic [1:0]    rd_sel;
   logic [7:0]    rd_data, status;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr),
      .rd_a0(rd_a0), .eng_done(eng_done), .eng_fail(eng_fail), .eng_vfault(eng_vfault),
      .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_start(erase_start), .erase_addr(erase_addr), .susp_req(susp_req),
      .resume_req(resume_req), .rd_sel(rd_sel), .rd_data(rd_data), .status(status)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pulses_zero(input string req);
      chk(req, "request pulses", {28'd0, prog_start, erase_start, susp_req, resume_req}, 32'd0);
   endtask

   // called on a falling edge; returns one rising edge later on the next falling edge
   task automatic wr(input logic [DW-1:0] d, input logic [AW-1:0] a);
      wr_data = d; wr_addr = a; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic done(input logic fail, input logic vf);
      eng_done = 1'b1; eng_fail = fail; eng_vfault = vf;
      @(negedge clk);
      eng_done = 1'b0; eng_fail = 1'b0; eng_vfault = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "rd_sel", rd_sel, 2'b00);
      chk("R1", "status", status, 8'h80);
      pulses_zero("R1");
   endtask

   task automatic t_upper_byte;
      wr(16'hFF70, '0);
      chk("R2", "rd_sel after FF70", rd_sel, 2'b10);
      chk("R3", "rd_data = status", rd_data, status);
      wr(16'h70FF, '0);
      chk("R2", "rd_sel after 70FF", rd_sel, 2'b00);
      wr(16'h9000, '0);
      chk("R2", "rd_sel after 9000", rd_sel, 2'b00);
   endtask

   task automatic t_ident;
      wr(16'h0090, 18'h3FFFF);
      chk("R4", "rd_sel", rd_sel, 2'b01);
      rd_a0 = 1'b0; #1;
      chk("R4", "manufacturer id", rd_data, MFR);
      rd_a0 = 1'b1; #1;
      chk("R4", "device id", rd_data, DEV);
      rd_a0 = 1'b0;
      @(negedge clk);
      wr(16'h00FF, '0);
      chk("R3", "back to array", rd_sel, 2'b00);
   endtask

   task automatic t_program;
      wr(16'h0040, 18'h00001);
      pulses_zero("R5");
      wr(16'h1234, 18'h2ABCD);
      chk("R5", "prog_start", prog_start, 1'b1);
      chk("R5", "prog_addr", prog_addr, 18'h2ABCD);
      chk("R5", "prog_data", prog_data, 16'h1234);
      chk("R5", "rd_sel", rd_sel, 2'b10);
      chk("R5", "status busy", status, 8'h00);
      wr(16'h00FF, '0);
      chk("R5", "prog_start one cycle", prog_start, 1'b0);
      chk("R12", "FF ignored while busy", rd_sel, 2'b10);
      wr(16'h0040, '0);
      wr(16'h5555, '0);
      pulses_zero("R12");
      done(1'b0, 1'b0);
      chk("R5", "status ready after done", status, 8'h80);
      wr(16'h00FF, '0);
      chk("R3", "array after FF", rd_sel, 2'b00);
   endtask

   task automatic t_erase_ok;
      wr(16'h0020, 18'h00111);
      wr(16'h00D0, 18'h3F000);
      chk("R6", "erase_start", erase_start, 1'b1);
      chk("R6", "erase_addr", erase_addr, 18'h3F000);
      chk("R6", "status busy", status, 8'h00);
      @(negedge clk);
      chk("R6", "erase_start one cycle", erase_start, 1'b0);
      done(1'b0, 1'b0);
      chk("R6", "status after done", status, 8'h80);
      wr(16'h00FF, '0);
   endtask

   task automatic t_erase_bad;
      wr(16'h0020, '0);
      wr(16'h00FF, 18'h00123);
      pulses_zero("R7");
      chk("R7", "status", status, 8'hB0);
      chk("R7", "rd_sel", rd_sel, 2'b10);
      wr(16'h00FF, '0);
      chk("R10", "sticky across FF", status, 8'hB0);
      wr(16'h0050, '0);
      chk("R10", "clear", status, 8'h80);
   endtask

   task automatic t_suspend;
      wr(16'h0020, '0);
      wr(16'h00D0, 18'h10000);
      wr(16'h00B0, '0);
      chk("R8", "susp_req", susp_req, 1'b1);
      chk("R8", "status suspended", status, 8'hC0);
      wr(16'h0090, '0);
      chk("R8", "90 ignored in suspend", rd_sel, 2'b10);
      wr(16'h0040, '0);
      wr(16'h1111, '0);
      pulses_zero("R8");
      wr(16'h00FF, '0);
      chk("R8", "FF in suspend", rd_sel, 2'b00);
      wr(16'h0070, '0);
      chk("R8", "70 in suspend", rd_sel, 2'b10);
      wr(16'h00FF, '0);
      wr(16'h00D0, '0);
      chk("R8", "resume_req", resume_req, 1'b1);
      chk("R8", "status resumed", status, 8'h00);
      chk("R8", "rd_sel after resume", rd_sel, 2'b10);
      wr(16'h0050, '0);
      chk("R12", "busy erase ignores 50", status, 8'h00);
      done(1'b0, 1'b0);
      chk("R8", "status after done", status, 8'h80);
      wr(16'h00FF, '0);
   endtask

   task automatic t_reserved;
      wr(16'h0000, '0);
      chk("R9", "00 rd_sel", rd_sel, 2'b00);
      pulses_zero("R9");
      wr(16'h00D0, '0);
      pulses_zero("R9");
      wr(16'h00B0, '0);
      pulses_zero("R9");
      wr(16'h0033, '0);
      chk("R9", "33 rd_sel", rd_sel, 2'b00);
      chk("R9", "status", status, 8'h80);
   endtask

   task automatic t_fail_bits;
      wr(16'h0010, '0);
      wr(16'hAAAA, 18'h00042);
      chk("R5", "10h starts program", prog_start, 1'b1);
      done(1'b1, 1'b0);
      chk("R11", "program fail", status, 8'h90);
      wr(16'h0050, '0);
      chk("R10", "clear after program fail", status, 8'h80);
      wr(16'h0020, '0);
      wr(16'h00D0, '0);
      done(1'b1, 1'b1);
      chk("R11", "erase fail + fault", status, 8'hA8);
      wr(16'h0050, '0);
      chk("R10", "clear bits 5:3", status, 8'h80);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_upper_byte();
      t_ident();
      t_program();
      t_erase_ok();
      t_erase_bad();
      t_suspend();
      t_reserved();
      t_fail_bits();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule